// File: doc/BRIEF.md
# Static Branch Direction Predictor

This unit steers instruction fetch past a conditional branch without keeping any record of earlier outcomes. A branch arrives with its address, a signed byte offset, and a one-bit likely/unlikely hint from its encoding. A two-bit policy input chooses one of four fixed rules: never taken, always taken, taken only when the branch points backward, or follow the hint. From that rule the unit produces the guessed direction and the next fetch address in the same cycle.

One cycle later the real outcome arrives. The unit compares it with the guess it stored. On a mismatch it raises a one-cycle squash, which cancels the single instruction fetched on the wrong path, and it gives the address fetch must restart from. A wrong guess costs only that one slot and the redirect; it never changes results. Two saturating counters track how many branches resolved and how many of them were mispredicted.

Top module: `static_branch_steer`

## Requirements
- R1: With policy 2'b00 the prediction is not taken and the predicted next address is branch address + 4, whatever the offset and hint.
- R2: With policy 2'b01 the prediction is taken and the predicted next address is branch address + 4 + offset (offset in two's complement).
- R3: With policy 2'b10 the prediction is taken exactly when the offset's most significant bit is 1 (a backward branch); a zero or positive offset is predicted not taken, and the hint has no effect.
- R4: With policy 2'b11 the prediction is taken exactly when the hint is 1; the offset's sign has no effect.
- R5: squash is high in a cycle exactly when a resolution (res_valid=1) arrives in the cycle after a valid branch and res_taken differs from the direction predicted for that branch; it lasts only that cycle.
- R6: During squash, fix_pc is branch address + 4 when the branch was predicted taken but resolved not taken, and branch address + 4 + offset when predicted not taken but resolved taken.
- R7: A resolution that does not follow a valid branch in the previous cycle is ignored: no squash and no change to either counter.
- R8: branch_count rises by one for every accepted resolution and mispredict_count by one for every squash, each visible on the clock edge ending that cycle; both are zero after reset.
- R9: Both counters stop at all ones and stay there.
- R10: Address arithmetic wraps modulo 2^PC_W.
- R11: Branches may arrive on back-to-back cycles; each resolution is judged against the branch from the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | A conditional branch is presented this cycle |
| br_pc | input | PC_W | Address of the branch |
| br_offset | input | PC_W | Signed byte offset, added to address + 4 |
| br_hint | input | 1 | Encoding hint: 1 likely taken, 0 unlikely |
| policy | input | 2 | 00 never taken, 01 always taken, 10 backward taken, 11 hint |
| pred_taken | output | 1 | Guessed direction for the presented branch |
| pred_next_pc | output | PC_W | Fetch address implied by the guess |
| res_valid | input | 1 | Actual outcome of last cycle's branch is presented |
| res_taken | input | 1 | Actual outcome, 1 taken |
| squash | output | 1 | Cancel the wrong-path instruction this cycle |
| fix_pc | output | PC_W | Restart address, meaningful while squash is high |
| branch_count | output | CNT_W | Saturating count of resolved branches |
| mispredict_count | output | CNT_W | Saturating count of mispredictions |

## Verification
The bench drives each policy with backward, forward and zero offsets and both hint values, since a design that reads the wrong offset bit or treats zero as backward would flip the guess and the fetch address. It resolves branches both ways against each guess, so an inverted compare would squash correct guesses and a swapped restart address would send fetch down the path just abandoned. It sends resolutions with no branch before them, which a design without its own pending flag would count or squash, and it runs back-to-back branches so that a design judging a resolution against the current branch rather than the stored one gets it wrong. It drives the counters past all ones to catch wrap to zero, and uses addresses near the top of the range to catch carry errors.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    POL_NEVER    = 2'b00,
    POL_ALWAYS   = 2'b01,
    POL_BACKWARD = 2'b10,
    POL_HINT     = 2'b11
  } steer_policy_e;

  localparam int unsigned INSN_BYTES = 4;

  // Direction rule; offset sign and hint are the only operands.
  function automatic logic pick_direction(steer_policy_e pol, logic off_neg, logic hint);
    logic dir;
    unique case (pol)
      POL_NEVER:    dir = 1'b0;
      POL_ALWAYS:   dir = 1'b1;
      POL_BACKWARD: dir = off_neg;
      POL_HINT:     dir = hint;
      default:      dir = 1'b0;
    endcase
    return dir;
  endfunction

endpackage

// File: rtl/sbp_policy.sv
module sbp_policy
  import sbp_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic [1:0]      policy,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] offset,
  input  logic            hint,
  output logic            taken,
  output logic [PC_W-1:0] next_pc,
  output logic [PC_W-1:0] fall_pc,
  output logic [PC_W-1:0] tgt_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  function automatic logic [PC_W-1:0] seq_addr(logic [PC_W-1:0] a);
    return a + STEP;
  endfunction

  function automatic logic [PC_W-1:0] jump_addr(logic [PC_W-1:0] a, logic [PC_W-1:0] o);
    return seq_addr(a) + o;
  endfunction

  steer_policy_e pol;
  logic          off_neg;

  assign pol     = steer_policy_e'(policy);
  assign off_neg = offset[PC_W-1];
  assign fall_pc = seq_addr(pc);
  assign tgt_pc  = jump_addr(pc, offset);
  assign taken   = pick_direction(pol, off_neg, hint);
  assign next_pc = taken ? tgt_pc : fall_pc;

endmodule

// File: rtl/sbp_resolve.sv
module sbp_resolve #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic            pred_taken,
  input  logic [PC_W-1:0] fall_pc,
  input  logic [PC_W-1:0] tgt_pc,
  input  logic            res_valid,
  input  logic            res_taken,
  output logic            accepted,
  output logic            squash,
  output logic [PC_W-1:0] fix_pc
);

  logic            pend_valid;
  logic            pend_taken;
  logic [PC_W-1:0] pend_fall;
  logic [PC_W-1:0] pend_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_taken <= 1'b0;
      pend_fall  <= '0;
      pend_tgt   <= '0;
    end else begin
      pend_valid <= br_valid;
      if (br_valid) begin
        pend_taken <= pred_taken;
        pend_fall  <= fall_pc;
        pend_tgt   <= tgt_pc;
      end
    end
  end

  logic wrong_way;
  assign accepted  = res_valid & pend_valid;
  assign wrong_way = res_taken ^ pend_taken;
  assign squash    = accepted & wrong_way;
  assign fix_pc    = pend_taken ? pend_fall : pend_tgt;

  // R7: no squash without a branch in the cycle before
  assert_squash_needs_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> ($past(br_valid) && res_valid));

  // R5: squash only when outcome disagrees with the guess made last cycle
  assert_squash_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (res_taken != $past(pred_taken)));

  // R5: a matching outcome never squashes
  assert_no_squash_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(br_valid) && res_valid && res_taken == $past(pred_taken)) |-> !squash);

  // R6: restart address follows the real outcome
  assert_fix_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && res_taken) |-> (fix_pc == $past(tgt_pc)));
  assert_fix_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && !res_taken) |-> (fix_pc == $past(fall_pc)));

endmodule

// File: rtl/sbp_counter.sv
module sbp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v, logic go);
    return (go && v != TOP) ? v + 1'b1 : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= bump(cnt, inc);
  end

  // R9: a counter never goes down (no wrap past all ones)
  assert_cnt_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= $past(cnt));

  // R8: a counter moves only when asked
  assert_cnt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inc) |-> $stable(cnt));

endmodule

// File: rtl/static_branch_steer.sv
module static_branch_steer #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [PC_W-1:0]  br_pc,
  input  logic [PC_W-1:0]  br_offset,
  input  logic             br_hint,
  input  logic [1:0]       policy,
  output logic             pred_taken,
  output logic [PC_W-1:0]  pred_next_pc,
  input  logic             res_valid,
  input  logic             res_taken,
  output logic             squash,
  output logic [PC_W-1:0]  fix_pc,
  output logic [CNT_W-1:0] branch_count,
  output logic [CNT_W-1:0] mispredict_count
);

  localparam int unsigned N_CNT = 2;

  logic [PC_W-1:0] fall_pc;
  logic [PC_W-1:0] tgt_pc;
  logic            accepted;

  sbp_policy #(.PC_W(PC_W)) u_policy (
    .policy  (policy),
    .pc      (br_pc),
    .offset  (br_offset),
    .hint    (br_hint),
    .taken   (pred_taken),
    .next_pc (pred_next_pc),
    .fall_pc (fall_pc),
    .tgt_pc  (tgt_pc)
  );

  sbp_resolve #(.PC_W(PC_W)) u_resolve (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_valid   (br_valid),
    .pred_taken (pred_taken),
    .fall_pc    (fall_pc),
    .tgt_pc     (tgt_pc),
    .res_valid  (res_valid),
    .res_taken  (res_taken),
    .accepted   (accepted),
    .squash     (squash),
    .fix_pc     (fix_pc)
  );

  logic [N_CNT-1:0]            cnt_inc;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_val;

  assign cnt_inc = {squash, accepted};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    sbp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .cnt   (cnt_val[g])
    );
  end

  assign branch_count     = cnt_val[0];
  assign mispredict_count = cnt_val[1];

  // R1
  assert_never_policy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'b00) |-> (!pred_taken && pred_next_pc == br_pc + PC_W'(4)));
  // R2
  assert_always_policy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'b01) |-> (pred_taken && pred_next_pc == br_pc + PC_W'(4) + br_offset));
  // R3
  assert_backward_policy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'b10) |-> (pred_taken == br_offset[PC_W-1]));
  // R4
  assert_hint_policy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'b11) |-> (pred_taken == br_hint));
  // R8: mispredictions never outnumber resolved branches
  assert_miss_within_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict_count <= branch_count);

endmodule

// File: tb/sim_static_branch_steer.sv
`timescale 1ns/1ps
module sim_static_branch_steer;

  localparam int PC_W  = 32;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             br_valid = 1'b0;
  logic [PC_W-1:0]  br_pc = '0;
  logic [PC_W-1:0]  br_offset = '0;
  logic             br_hint = 1'b0;
  logic [1:0]       policy = 2'b00;
  logic             pred_taken;
  logic [PC_W-1:0]  pred_next_pc;
  logic             res_valid = 1'b0;
  logic             res_taken = 1'b0;
  logic             squash;
  logic [PC_W-1:0]  fix_pc;
  logic [CNT_W-1:0] branch_count;
  logic [CNT_W-1:0] mispredict_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [CNT_W-1:0] exp_br = '0;
  logic [CNT_W-1:0] exp_mis = '0;

  always #4 clk = ~clk;

  static_branch_steer #(.PC_W(PC_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
    .br_offset(br_offset), .br_hint(br_hint), .policy(policy),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .res_valid(res_valid), .res_taken(res_taken), .squash(squash),
    .fix_pc(fix_pc), .branch_count(branch_count),
    .mispredict_count(mispredict_count)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic model_dir(logic [1:0] pol, logic [PC_W-1:0] off, logic h);
    if (pol == 2'b00) return 1'b0;
    if (pol == 2'b01) return 1'b1;
    if (pol == 2'b10) return off[PC_W-1];
    return h;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  // One branch, resolved in the next cycle, with all checks.
  task automatic run_branch(string req, logic [1:0] pol, logic [PC_W-1:0] pc,
                            logic [PC_W-1:0] off, logic h, logic actual);
    logic d;
    logic [PC_W-1:0] fall, tgt;
    d    = model_dir(pol, off, h);
    fall = pc + 32'd4;
    tgt  = pc + 32'd4 + off;
    @(negedge clk);
    br_valid = 1'b1; br_pc = pc; br_offset = off; br_hint = h; policy = pol;
    res_valid = 1'b0;
    #1;
    check(req, "pred_taken", 64'(pred_taken), 64'(d));
    check(req, "pred_next_pc", 64'(pred_next_pc), 64'(d ? tgt : fall));
    @(negedge clk);
    br_valid = 1'b0; res_valid = 1'b1; res_taken = actual;
    #1;
    check("R5", "squash on resolve", 64'(squash), 64'(actual != d));
    if (actual != d) check("R6", "fix_pc", 64'(fix_pc), 64'(actual ? tgt : fall));
    exp_br = sat_inc(exp_br);
    if (actual != d) exp_mis = sat_inc(exp_mis);
    @(negedge clk);
    res_valid = 1'b0;
    #1;
    check("R5", "squash one cycle", 64'(squash), 64'(0));
    check("R8", "branch_count", 64'(branch_count), 64'(exp_br));
    check("R8", "mispredict_count", 64'(mispredict_count), 64'(exp_mis));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8", "reset branch_count", 64'(branch_count), 64'(0));
    check("R8", "reset mispredict_count", 64'(mispredict_count), 64'(0));
    check("R5", "reset squash", 64'(squash), 64'(0));
  endtask

  task automatic t_never();
    run_branch("R1", 2'b00, 32'h0000_1000, 32'h0000_0040, 1'b1, 1'b0);
    run_branch("R1", 2'b00, 32'h0000_2000, 32'hFFFF_FFF0, 1'b1, 1'b1);
  endtask

  task automatic t_always();
    run_branch("R2", 2'b01, 32'h0000_3000, 32'hFFFF_FF00, 1'b0, 1'b1);
    run_branch("R2", 2'b01, 32'h0000_3400, 32'h0000_0100, 1'b0, 1'b0);
  endtask

  task automatic t_backward();
    run_branch("R3", 2'b10, 32'h0000_5000, 32'hFFFF_FFF8, 1'b0, 1'b1);
    run_branch("R3", 2'b10, 32'h0000_5000, 32'h0000_0008, 1'b1, 1'b1);
    run_branch("R3", 2'b10, 32'h0000_5100, 32'h0000_0000, 1'b1, 1'b0);
    run_branch("R3", 2'b10, 32'h0000_5200, 32'h8000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_hint();
    run_branch("R4", 2'b11, 32'h0000_6000, 32'h0000_0020, 1'b1, 1'b1);
    run_branch("R4", 2'b11, 32'h0000_6000, 32'hFFFF_FFE0, 1'b0, 1'b1);
    run_branch("R4", 2'b11, 32'h0000_6100, 32'hFFFF_FFE0, 1'b1, 1'b0);
  endtask

  task automatic t_wrap();
    run_branch("R10", 2'b01, 32'hFFFF_FFF8, 32'h0000_0010, 1'b0, 1'b0);
    run_branch("R10", 2'b00, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0, 1'b1);
  endtask

  task automatic t_orphan();
    @(negedge clk);
    br_valid = 1'b0; res_valid = 1'b1; res_taken = 1'b1; policy = 2'b00;
    #1;
    check("R7", "orphan squash", 64'(squash), 64'(0));
    @(negedge clk);
    res_taken = 1'b0; policy = 2'b01;
    #1;
    check("R7", "orphan squash 2", 64'(squash), 64'(0));
    @(negedge clk);
    res_valid = 1'b0;
    #1;
    check("R7", "orphan branch_count", 64'(branch_count), 64'(exp_br));
    check("R7", "orphan mispredict_count", 64'(mispredict_count), 64'(exp_mis));
  endtask

  // Branches every cycle; each resolution belongs to the previous branch.
  task automatic t_back_to_back();
    logic [PC_W-1:0] pcs[4] = '{32'h100, 32'h200, 32'h300, 32'h400};
    logic [1:0]      pols[4] = '{2'b01, 2'b00, 2'b01, 2'b10};
    logic            acts[4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    logic            pd;
    logic [PC_W-1:0] off;
    off = 32'h0000_0080;
    pd  = 1'b0;
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk);
      br_valid  = (i < 4);
      res_valid = (i > 0);
      if (i > 0) res_taken = acts[i-1];
      if (i < 4) begin br_pc = pcs[i]; br_offset = off; policy = pols[i]; br_hint = 1'b0; end
      #1;
      if (i > 0) begin
        check("R11", "squash pipelined", 64'(squash), 64'(acts[i-1] != pd));
        if (acts[i-1] != pd)
          check("R11", "fix_pc pipelined", 64'(fix_pc),
                64'(acts[i-1] ? pcs[i-1] + 32'd4 + off : pcs[i-1] + 32'd4));
        exp_br = sat_inc(exp_br);
        if (acts[i-1] != pd) exp_mis = sat_inc(exp_mis);
      end
      if (i < 4) pd = model_dir(pols[i], off, 1'b0);
    end
    @(negedge clk);
    res_valid = 1'b0; br_valid = 1'b0;
    #1;
    check("R8", "branch_count after burst", 64'(branch_count), 64'(exp_br));
    check("R8", "mispredict_count after burst", 64'(mispredict_count), 64'(exp_mis));
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      br_valid = 1'b1; policy = 2'b00; br_pc = 32'h8000; br_offset = 32'h40;
      res_valid = (i > 0); res_taken = 1'b1;
      if (i > 0) begin exp_br = sat_inc(exp_br); exp_mis = sat_inc(exp_mis); end
    end
    @(negedge clk);
    br_valid = 1'b0; res_valid = 1'b0;
    #1;
    check("R9", "branch_count saturated", 64'(branch_count), 64'(CMAX));
    check("R9", "mispredict_count saturated", 64'(mispredict_count), 64'(CMAX));
    run_branch("R9", 2'b00, 32'h9000, 32'h10, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_never();
    t_always();
    t_backward();
    t_hint();
    t_wrap();
    t_orphan();
    t_back_to_back();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule